// File: doc/BRIEF.md
# Simultaneous Servo Pulse Generator

This block turns a bank of decoded channel positions into servo pulses on up to sixteen lines at once. A receiver's frame decoder presents the positions together with a load strobe and a flag that says whether the subframe passed its integrity check. A separate strobe marks the end of subframe reception. At that strobe every servo line goes high in the same clock cycle. Each line then stays high for a fixed base time plus its position code, counted in microseconds.

A position set is adopted only from a load that carries the good-frame flag. A load whose check failed is dropped, so the next subframe strobe repeats the last good set. Loads and starts that arrive while pulses are running are held and take effect at the next start, so a pulse that has begun always runs to its full length. The microsecond time base comes from an internal clock prescaler, which is realigned at every start. A parameter can replace it with an external tick input.

Top module: `servo_burst_gen`

## Requirements
- R1: After reset, and until a load with the good-frame flag has been accepted, every pulse line and the busy flag stay low, even when start strobes arrive.
- R2: When a burst begins, all pulse lines go high in the same clock cycle, and only when every line was low before.
- R3: With the internal time base, channel k is high for exactly (BASE_US + code) × CLK_PER_US clock cycles. The code is an unsigned CODE_W-bit field at bits [k·CODE_W +: CODE_W] of the position bank.
- R4: A start strobe sampled while all lines are idle and a good set exists makes the lines high from the very next clock edge. This is a one-cycle latency.
- R5: A load with the good-frame flag low has no effect. Every later start replays the widths of the last good set, as many times as starts arrive.
- R6: A good load accepted while pulses are active leaves the running pulses unchanged, and its widths are used from the next start.
- R7: A start strobe that arrives while pulses are active is held. The new burst begins on the first clock edge after the last line has fallen, and no running pulse is cut short.
- R8: The busy flag is high while any pulse line is high, and it is low once all lines are low.
- R9: The extreme codes 0 and 2^CODE_W−1 give widths of BASE_US and BASE_US + 2^CODE_W − 1 microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_bank_i | input | NUM_CH*CODE_W | Channel position codes, channel k at bits [k*CODE_W +: CODE_W] |
| load_i | input | 1 | Position bank present this cycle |
| frame_ok_i | input | 1 | Integrity check passed for the bank being loaded |
| sub_start_i | input | 1 | Subframe reception finished; start a burst |
| us_tick_i | input | 1 | External microsecond tick, used only when TICK_SRC selects it |
| pulse_o | output | NUM_CH | Servo pulse lines |
| busy_o | output | 1 | At least one pulse line is high |

## Verification
The bench builds the block with sixteen channels, 10-bit codes, a base of 8 µs and a prescaler of 4 clocks per microsecond. With these values the widest pulse lasts about four thousand cycles, which lets a single run reach the all-zero and all-ones codes, replays after rejected loads, and loads and starts that overlap a running burst. Because the prescaler ratio is small, every width is an exact cycle count, so an off-by-one in the tick or counter logic shows up at the scoreboard as a width that differs by four cycles.

// File: rtl/servo_pkg.sv
package servo_pkg;

   localparam int unsigned MAX_CH = 64;

   typedef enum logic {
      TICK_INTERNAL = 1'b0,
      TICK_EXTERNAL = 1'b1
   } tick_src_e;

endpackage

// File: rtl/servo_us_tick.sv
module servo_us_tick #(
   parameter servo_pkg::tick_src_e SRC = servo_pkg::TICK_INTERNAL,
   parameter int unsigned          DIV = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic realign_i,
   input  logic ext_tick_i,
   output logic tick_o
);

   generate
      if (SRC == servo_pkg::TICK_INTERNAL) begin : g_int
         localparam int unsigned PW   = (DIV > 1) ? $clog2(DIV) : 1;
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;
         logic          unused_ext;

         always_ff @(posedge clk) begin
            if (!rst_n)             pre_q <= '0;
            else if (realign_i)     pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end

         assign tick_o     = !realign_i && (pre_q == LAST);
         assign unused_ext = ext_tick_i;
      end else begin : g_ext
         logic unused_realign;
         assign tick_o         = ext_tick_i;
         assign unused_realign = realign_i;
      end
   endgenerate

endmodule

// File: rtl/servo_pos_store.sv
module servo_pos_store #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CODE_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CODE_W-1:0] bank_i,
   input  logic                     load_i,
   input  logic                     ok_i,
   input  logic                     apply_i,
   output logic [NUM_CH*CODE_W-1:0] sel_o,
   output logic                     have_o
);

   localparam int unsigned BW = NUM_CH * CODE_W;

   logic [BW-1:0] pend_q, act_q;
   logic          pend_v_q, have_q;

   assign sel_o  = pend_v_q ? pend_q : act_q;
   assign have_o = pend_v_q | have_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         act_q    <= '0;
         pend_v_q <= 1'b0;
         have_q   <= 1'b0;
      end else begin
         if (apply_i) begin
            act_q    <= sel_o;
            have_q   <= have_o;
            pend_v_q <= 1'b0;
         end
         if (load_i && ok_i) begin
            pend_q   <= bank_i;
            pend_v_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/servo_pulse_chan.sv
module servo_pulse_chan #(
   parameter int unsigned CODE_W  = 10,
   parameter int unsigned BASE_US = 1000,
   parameter int unsigned CNT_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pulse_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (fire_i)                  cnt_q <= CNT_W'(BASE_US) + CNT_W'(code_i);
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/servo_burst_gen.sv
module servo_burst_gen #(
   parameter int unsigned          NUM_CH     = 16,
   parameter int unsigned          CODE_W     = 10,
   parameter int unsigned          BASE_US    = 1000,
   parameter int unsigned          CLK_PER_US = 200,
   parameter servo_pkg::tick_src_e TICK_SRC   = servo_pkg::TICK_INTERNAL
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CODE_W-1:0] pos_bank_i,
   input  logic                     load_i,
   input  logic                     frame_ok_i,
   input  logic                     sub_start_i,
   input  logic                     us_tick_i,
   output logic [NUM_CH-1:0]        pulse_o,
   output logic                     busy_o
);

   localparam int unsigned CNT_W = $clog2(BASE_US + (1 << CODE_W)) + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > servo_pkg::MAX_CH) begin : g_bad_ch
         $error("servo_burst_gen: NUM_CH out of range");
      end
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
         $error("servo_burst_gen: CODE_W out of range");
      end
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("servo_burst_gen: CLK_PER_US must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0]        pulse_w;
   logic [NUM_CH*CODE_W-1:0] sel_w;
   logic                     tick_w, fire_w, have_w, busy_w, pend_start_q;

   assign busy_w = |pulse_w;
   assign fire_w = (sub_start_i | pend_start_q) & ~busy_w & have_w;

   // a start that meets running pulses waits until all have ended
   always_ff @(posedge clk) begin
      if (!rst_n) pend_start_q <= 1'b0;
      else        pend_start_q <= (sub_start_i | pend_start_q) & busy_w;
   end

   servo_us_tick #(.SRC(TICK_SRC), .DIV(CLK_PER_US)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .realign_i (fire_w),
      .ext_tick_i(us_tick_i),
      .tick_o    (tick_w)
   );

   servo_pos_store #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .bank_i (pos_bank_i),
      .load_i (load_i),
      .ok_i   (frame_ok_i),
      .apply_i(fire_w),
      .sel_o  (sel_w),
      .have_o (have_w)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
         servo_pulse_chan #(.CODE_W(CODE_W), .BASE_US(BASE_US), .CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire_i (fire_w),
            .tick_i (tick_w),
            .code_i (sel_w[k*CODE_W +: CODE_W]),
            .pulse_o(pulse_w[k])
         );
      end
   endgenerate

   assign pulse_o = pulse_w;
   assign busy_o  = busy_w;

endmodule

// File: rtl/servo_burst_chk.sv
module servo_burst_chk #(
   parameter int unsigned NUM_CH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              frame_ok_i,
   input logic              sub_start_i,
   input logic              tick_i,
   input logic [NUM_CH-1:0] pulse_o,
   input logic              busy_o
);

   logic seen_good_q, req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_good_q <= 1'b0;
         req_q       <= 1'b0;
      end else begin
         if (load_i && frame_ok_i) seen_good_q <= 1'b1;
         if (sub_start_i)                               req_q <= 1'b1;
         else if (|(pulse_o & ~$past(pulse_o)))         req_q <= 1'b0;
      end
   end

   // R1
   idle_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_good_q |-> (pulse_o == '0 && !busy_o));

   // R2
   joint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pulse_o & ~$past(pulse_o))) |-> ($past(pulse_o) == '0 && !$past(busy_o)));

   // R7
   no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pulse_o) & ~pulse_o)) |-> $past(tick_i));

   // R4
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pulse_o & ~$past(pulse_o))) |-> (req_q || $past(sub_start_i)));

endmodule

bind servo_burst_gen servo_burst_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .frame_ok_i (frame_ok_i),
   .sub_start_i(sub_start_i),
   .tick_i     (tick_w),
   .pulse_o    (pulse_o),
   .busy_o     (busy_o)
);

// File: tb/sim_servo_burst_gen.sv
`timescale 1ns/1ps
module sim_servo_burst_gen;

   localparam int NUM_CH = 16;
   localparam int CODE_W = 10;
   localparam int BASE   = 8;
   localparam int DIV    = 4;
   localparam int MAXC   = (1 << CODE_W) - 1;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [NUM_CH*CODE_W-1:0] pos_bank = '0;
   logic                     load = 1'b0, frame_ok = 1'b0, sub_start = 1'b0;
   logic [NUM_CH-1:0]        pulse_w;
   logic                     busy_w;

   int n_chk = 0, n_fail = 0;
   int cur_codes  [NUM_CH];
   int good_codes [NUM_CH];
   int hi_cnt     [NUM_CH];
   int exp_q [$];
   string tag_q [$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   servo_burst_gen #(
      .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BASE_US(BASE), .CLK_PER_US(DIV),
      .TICK_SRC(servo_pkg::TICK_INTERNAL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pos_bank_i(pos_bank), .load_i(load),
      .frame_ok_i(frame_ok), .sub_start_i(sub_start), .us_tick_i(1'b0),
      .pulse_o(pulse_w), .busy_o(busy_w)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_load(input bit ok);
      @(negedge clk);
      for (int k = 0; k < NUM_CH; k++) pos_bank[k*CODE_W +: CODE_W] = CODE_W'(cur_codes[k]);
      load = 1'b1;
      frame_ok = ok;
      @(negedge clk);
      load = 1'b0;
      frame_ok = 1'b0;
      if (ok) for (int k = 0; k < NUM_CH; k++) good_codes[k] = cur_codes[k];
   endtask

   // push expected widths, strobe start; optionally check the 1-cycle latency
   task automatic do_start(input string tag, input bit chk_now);
      @(negedge clk);
      for (int k = 0; k < NUM_CH; k++) exp_q.push_back((BASE + good_codes[k]) * DIV);
      tag_q.push_back(tag);
      sub_start = 1'b1;
      @(negedge clk);
      sub_start = 1'b0;
      if (chk_now) begin
         chk(pulse_w == {NUM_CH{1'b1}}, "R4 lines high one cycle after start", pulse_w, {NUM_CH{1'b1}});
         chk(busy_w == 1'b1, "R8 busy while pulses active", busy_w, 1);
      end
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (pulse_w != '0);
   endtask

   // scoreboard monitor
   initial begin : monitor
      forever begin
         @(negedge clk);
         if (rst_n && pulse_w != '0) begin
            chk(pulse_w == {NUM_CH{1'b1}}, "R2 all lines rise together", pulse_w, {NUM_CH{1'b1}});
            for (int k = 0; k < NUM_CH; k++) hi_cnt[k] = int'(pulse_w[k]);
            while (pulse_w != '0) begin
               @(negedge clk);
               for (int k = 0; k < NUM_CH; k++) hi_cnt[k] += int'(pulse_w[k]);
            end
            if (exp_q.size() < NUM_CH || tag_q.size() == 0) begin
               chk(1'b0, "R1 unexpected burst", 1, 0);
            end else begin
               automatic string t = tag_q.pop_front();
               for (int k = 0; k < NUM_CH; k++) begin
                  automatic int w = exp_q.pop_front();
                  chk(hi_cnt[k] == w, t, hi_cnt[k], w);
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pulse_w == '0, "R1 lines low after reset", pulse_w, 0);
      chk(busy_w == 1'b0, "R1 busy low after reset", busy_w, 0);

      // R1: start without any good load does nothing
      @(negedge clk);
      sub_start = 1'b1;
      @(negedge clk);
      sub_start = 1'b0;
      repeat (30) @(negedge clk);
      chk(pulse_w == '0, "R1 no pulse before first good load", pulse_w, 0);

      // R1: a rejected load before any good one still gives nothing
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = 100;
      do_load(1'b0);
      @(negedge clk);
      sub_start = 1'b1;
      @(negedge clk);
      sub_start = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy_w == 1'b0, "R1 rejected load leaves lines idle", busy_w, 0);

      // R3: distinct codes per channel
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = k * 37 + 3;
      do_load(1'b1);
      do_start("R3 width per code", 1'b1);
      wait_idle();
      chk(busy_w == 1'b0, "R8 busy low when all lines low", busy_w, 0);

      // R5: rejected load then two starts replay the last good set
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = 900 - k;
      do_load(1'b0);
      do_start("R5 replay after rejected load", 1'b1);
      wait_idle();
      do_start("R5 second replay", 1'b1);
      wait_idle();

      // R9: extreme codes
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = (k % 2 == 0) ? 0 : MAXC;
      do_load(1'b1);
      do_start("R9 extreme codes", 1'b1);
      wait_idle();

      // R6: good load during an active burst
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = 20 + 5 * k;
      do_load(1'b1);
      do_start("R6 burst running during load", 1'b1);
      repeat (20) @(negedge clk);
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = 200 - 7 * k;
      do_load(1'b1);
      chk(busy_w == 1'b1, "R6 burst still active after load", busy_w, 1);
      wait_idle();
      do_start("R6 new set used at next start", 1'b1);
      wait_idle();

      // R7: start during an active burst is held until it ends
      for (int k = 0; k < NUM_CH; k++) cur_codes[k] = 10 + 3 * k;
      do_load(1'b1);
      do_start("R7 first burst not truncated", 1'b1);
      repeat (15) @(negedge clk);
      do_start("R7 held start burst", 1'b0);
      chk(busy_w == 1'b1, "R7 held start does not restart lines", busy_w, 1);
      wait_idle();
      @(negedge clk);
      chk(pulse_w == {NUM_CH{1'b1}}, "R7 held burst starts right after end", pulse_w, {NUM_CH{1'b1}});
      wait_idle();

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R3 every expected burst observed", exp_q.size(), 0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule